// File: doc/BRIEF.md
# SDRAM Command and Power-Mode Decoder

This block is the device-side front end of a four-bank SDRAM with a 16-bit data path split into two byte lanes. On every rising clock edge it registers the control, bank, address and mask pins. It then decodes one command per cycle from those registered pins and presents it as a strobe. The strobe carries the bank, the row or column, and an auto-precharge flag. The block keeps a per-bank record of which rows are open and which row each one holds. It also holds the mode op-code and flags commands that break the bank protocol.

Beside the command path, the block turns the byte masks into lane controls. Write masking acts in the cycle the mask is sampled, and read output disabling acts two clocks later. It also counts bursts so that a requested auto-precharge closes its bank once the access completes. When clock enable drops, it picks one of four low-power modes from the bank and burst state at that moment. The array, refresh timing, the meaning of the mode op-code and the pad behaviour belong elsewhere.

Top module: `sdram_cmd_front`

## Requirements
- R1: Pins are sampled on the rising edge, and the command decoded from the sampled pins appears on `cmd_code` after that edge. The pin order is {cs_n, ras_n, cas_n, we_n}. The decoding is 0011 → ACTIVE (code 1), 0101 → READ (2), 0100 → WRITE (3), 0010 → PRECHARGE (4), 0001 → REFRESH (5), 0000 → LOAD MODE (6). Every other value, including any value with cs_n high, gives code 0, and `cmd_valid` is then low.
- R2: An ACTIVE to a closed bank stores addr[11:0] as that bank's row and sets its `bank_open` bit one cycle after the command appears. `cmd_row` shows the incoming row for ACTIVE.
- R3: For READ and WRITE, `cmd_col` is addr[7:0] and `cmd_autopre` is addr[10]. `cmd_row` shows the row held for the addressed bank.
- R4: A READ or WRITE with addr[10] set starts a burst of BURST_LEN (4) cycles, counted from the cycle after the command. The addressed bank closes at the clock edge that ends the burst.
- R5: A PRECHARGE with addr[10] high closes every bank. With addr[10] low it closes only the bank on `ba`. The change shows on `bank_open` one cycle after the command.
- R6: `cmd_err` is high alongside the command strobe in any of three cases: a READ or WRITE to a closed bank, an ACTIVE to an open bank, or a LOAD MODE while any bank is open. A flagged command changes no state and starts no burst.
- R7: A LOAD MODE with every bank closed copies addr[11:0] to `mode_word` one cycle after the strobe. A rejected LOAD MODE leaves `mode_word` unchanged.
- R8: A write lane is enabled (`wr_lane_en[i]` high) during an accepted WRITE strobe and during the write burst that follows, unless the mask bit sampled in the same cycle is high. Mask bit 0 covers data bits 7:0 and mask bit 1 covers bits 15:8.
- R9: During a read burst, `rd_lane_oe[i]` is the inverse of mask bit i sampled two clock edges earlier. Outside a read burst both lanes are disabled.
- R10: When clock enable is sampled low in normal operation, `pm_mode` becomes one of four codes: 4 (clock suspend) if a burst is running; 3 (active power-down) if a row is open; 2 (self refresh) if the pins carry REFRESH with all banks idle; 1 (precharge power-down) otherwise. Normal operation is code 0.
- R11: In power-down or self refresh, raising clock enable returns `pm_mode` to 0 without any clock edge. Commands on the pins are ignored in every low-power mode and at the edge that leaves it.
- R12: In clock suspend the burst counter and the read-mask pipeline freeze. The mode ends only at a clock edge with clock enable high, and the burst then resumes its remaining cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column or op-code address |
| dqm | input | 2 | Byte-lane masks, bit 0 for the low byte |
| cmd_valid | output | 1 | A command was decoded this cycle |
| cmd_code | output | 3 | Decoded command code |
| cmd_bank | output | 2 | Bank of the decoded command |
| cmd_row | output | 12 | Row of the incoming ACTIVE, or the row held for the bank |
| cmd_col | output | 8 | Column of a READ or WRITE |
| cmd_autopre | output | 1 | Auto-precharge request of a READ or WRITE |
| cmd_err | output | 1 | Command breaks the bank protocol |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| pm_mode | output | 3 | Power mode code |
| wr_lane_en | output | 2 | Write data accepted per byte lane |
| rd_lane_oe | output | 2 | Read output driven per byte lane |
| mode_word | output | 12 | Last accepted mode op-code |

## Verification
A wrong bank record shows within one command. The next ACTIVE, READ or WRITE to that bank raises or drops `cmd_err` in the very cycle it is strobed, and `bank_open` shows the fault one cycle after the command that caused it. A burst counter that is off by one cycle moves the auto-precharge closure and the end of the read lane enables by that cycle. A counter that keeps running in clock suspend ends the burst early once the mode exits. A wrong mode choice or a late release appears on `pm_mode` at the edge where clock enable was sampled low, or at once when it rises again.

// File: rtl/sdram_fe_pkg.sv
// Shared types for the SDRAM command front end.
// Assumes active-low pins packed as {cs_n, ras_n, cas_n, we_n}.
package sdram_fe_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_LMR  = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        PM_RUN      = 3'd0,
        PM_PRE_PD   = 3'd1,
        PM_SELF_REF = 3'd2,
        PM_ACT_PD   = 3'd3,
        PM_SUSPEND  = 3'd4
    } pm_e;

    // Map the four control pins to a command; chip select high masks all.
    function automatic cmd_e decode_pins(input logic [3:0] ctl);
        cmd_e c;
        case (ctl)
            4'b0011: c = CMD_ACT;
            4'b0101: c = CMD_RD;
            4'b0100: c = CMD_WR;
            4'b0010: c = CMD_PRE;
            4'b0001: c = CMD_REF;
            4'b0000: c = CMD_LMR;
            default: c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fe_capture.sv
// Pin capture stage: registers control, bank, address and mask pins on the
// rising edge and decodes the registered control pins into a command.
// Assumes run_en is low in every low-power cycle; then a deselect is stored
// so nothing decodes, and the bank, address and mask registers hold.
module fe_capture
    import sdram_fe_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  dqm,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] bank_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  dqm_q
);

    logic [3:0] ctl_q;

    // Register the pins, or store a deselect while the clock is gated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= 4'b1111;
            bank_q <= '0;
            addr_q <= '0;
            dqm_q  <= '0;
        end else if (run_en) begin
            ctl_q  <= {cs_n, ras_n, cas_n, we_n};
            bank_q <= ba;
            addr_q <= addr;
            dqm_q  <= dqm;
        end else begin
            ctl_q  <= 4'b1111;
        end
    end

    // Decode the registered control pins.
    always_comb cmd = decode_pins(ctl_q);

    // R1, R11
    masked_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cmd == CMD_NONE));

endmodule

// File: rtl/fe_bank_track.sv
// Bank tracker: keeps per-bank open state and held rows plus the mode
// op-code, and flags protocol errors on the current command.
// Assumes flagged commands are dropped and that an auto-precharge closure
// is applied before the current command in the same cycle.
module fe_bank_track
    import sdram_fe_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              ap_close,
    input  logic [BANK_W-1:0] ap_bank,
    output logic [NBANK-1:0]  bank_open,
    output logic [NBANK-1:0]  open_nxt,
    output logic              cmd_err,
    output logic [ADDR_W-1:0] row_out,
    output logic [ADDR_W-1:0] mode_word
);

    logic [ADDR_W-1:0] row_r [NBANK];
    logic              act_ok;
    logic              pre_ok;
    logic              lmr_ok;

    // Protocol check of the current command against the open banks.
    always_comb begin
        case (cmd)
            CMD_ACT:         cmd_err = bank_open[bank];
            CMD_RD, CMD_WR:  cmd_err = !bank_open[bank];
            CMD_LMR:         cmd_err = |bank_open;
            default:         cmd_err = 1'b0;
        endcase
    end

    assign act_ok = (cmd == CMD_ACT) && !cmd_err;
    assign pre_ok = (cmd == CMD_PRE);
    assign lmr_ok = (cmd == CMD_LMR) && !cmd_err;

    // Per-bank next open state: closures first, then an accepted ACTIVE.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign open_nxt[g] =
            (bank_open[g]
             && !(ap_close && ap_bank == BANK_W'(g))
             && !(pre_ok && (addr_q[AP_BIT] || bank == BANK_W'(g))))
            || (act_ok && bank == BANK_W'(g));
    end

    // Commit open state and the mode op-code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_open <= '0;
            mode_word <= '0;
        end else begin
            bank_open <= open_nxt;
            if (lmr_ok) mode_word <= addr_q;
        end
    end

    // Store the row of each accepted ACTIVE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++) row_r[b] <= '0;
        end else begin
            for (int b = 0; b < NBANK; b++)
                if (act_ok && bank == BANK_W'(b)) row_r[b] <= addr_q;
        end
    end

    // Row shown with the strobe: incoming for ACTIVE, held otherwise.
    assign row_out = (cmd == CMD_ACT) ? addr_q : row_r[bank];

    // R2
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok |=> bank_open[$past(bank)]);

    // R5
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ok && addr_q[AP_BIT]) |=> (bank_open == '0));

    // R7
    lmr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_LMR) && cmd_err) |=> $stable(mode_word));

endmodule

// File: rtl/fe_burst_lane.sv
// Burst and lane control: counts the burst of an accepted READ or WRITE,
// closes the bank on auto-precharge at the burst's last edge, and derives
// write and read byte-lane enables from the masks.
// Assumes a new access cuts short any running burst.
module fe_burst_lane
    import sdram_fe_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int LANES     = 2,
    parameter int BURST_LEN = 4,
    localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  cmd_e              cmd,
    input  logic              cmd_err,
    input  logic [BANK_W-1:0] bank,
    input  logic              autopre,
    input  logic [LANES-1:0]  dqm_q,
    output logic              busy,
    output logic              ap_close,
    output logic [BANK_W-1:0] ap_bank,
    output logic [LANES-1:0]  wr_lane_en,
    output logic [LANES-1:0]  rd_lane_oe
);

    logic [CNT_W-1:0] cnt;
    logic             is_rd;
    logic             ap_pend;
    logic [LANES-1:0] dqm_d1;
    logic [LANES-1:0] dqm_d2;
    logic             rw_ok;
    logic             wr_now;
    logic             wr_burst;
    logic             rd_burst;

    assign rw_ok    = ((cmd == CMD_RD) || (cmd == CMD_WR)) && !cmd_err;
    assign wr_now   = (cmd == CMD_WR) && !cmd_err;
    assign wr_burst = (cnt != '0) && !is_rd;
    assign rd_burst = (cnt != '0) && is_rd;
    assign busy     = (cnt != '0) || rw_ok;
    assign ap_close = run_en && (cnt == CNT_W'(1)) && ap_pend;

    // Load or advance the burst counter; hold it while the clock is gated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            is_rd   <= 1'b0;
            ap_pend <= 1'b0;
            ap_bank <= '0;
        end else if (rw_ok) begin
            cnt     <= CNT_W'(BURST_LEN);
            is_rd   <= (cmd == CMD_RD);
            ap_pend <= autopre;
            ap_bank <= bank;
        end else if (run_en && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) ap_pend <= 1'b0;
        end
    end

    // Two-stage mask pipeline for read output disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqm_d1 <= '0;
            dqm_d2 <= '0;
        end else if (run_en) begin
            dqm_d1 <= dqm_q;
            dqm_d2 <= dqm_d1;
        end
    end

    // Per-lane enables.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wr_lane_en[i] = (wr_now || wr_burst) && !dqm_q[i];
        assign rd_lane_oe[i] = rd_burst && !dqm_d2[i];
    end

    // R12
    suspend_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt != '0) && !run_en && !rw_ok) |=> $stable(cnt));

    // R4
    ap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_close && !rw_ok) |=> (cnt == '0));

endmodule

// File: rtl/fe_power.sv
// Power-mode selector: on clock enable low in normal operation picks the
// low-power mode from burst and bank state; releases power-down and self
// refresh as soon as clock enable rises, clock suspend at the next edge.
// Assumes busy and any_open describe the state after the current edge.
module fe_power
    import sdram_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic self_req,
    input  logic any_open,
    input  logic busy,
    output pm_e  pm_mode,
    output logic run_en
);

    pm_e pm_state;

    assign run_en = cke && (pm_state == PM_RUN);

    // Mode register: enter on clock enable low, leave on clock enable high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_state <= PM_RUN;
        end else if (pm_state == PM_RUN) begin
            if (!cke) begin
                if (busy)          pm_state <= PM_SUSPEND;
                else if (any_open) pm_state <= PM_ACT_PD;
                else if (self_req) pm_state <= PM_SELF_REF;
                else               pm_state <= PM_PRE_PD;
            end
        end else if (cke) begin
            pm_state <= PM_RUN;
        end
    end

    // Reported mode: power-down and self refresh release without a clock.
    always_comb begin
        if (cke && (pm_state == PM_PRE_PD || pm_state == PM_SELF_REF
                    || pm_state == PM_ACT_PD))
            pm_mode = PM_RUN;
        else
            pm_mode = pm_state;
    end

    // R10
    suspend_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_RUN && !cke && busy) |=> (pm_mode == PM_SUSPEND));

    // R10
    idle_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_RUN && !cke && !busy && !any_open)
        |=> (pm_state == PM_PRE_PD || pm_state == PM_SELF_REF));

endmodule

// File: rtl/sdram_cmd_front.sv
// SDRAM command front end top: pin capture, bank tracking, burst and lane
// control and power-mode selection for a four-bank, two-lane device.
// Assumes the controller observes bank protocol; breaches raise cmd_err.
module sdram_cmd_front
    import sdram_fe_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 12,
    parameter int COL_W     = 8,
    parameter int AP_BIT    = 10,
    parameter int LANES     = 2,
    parameter int BURST_LEN = 4,
    localparam int NBANK    = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  dqm,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_autopre,
    output logic              cmd_err,
    output logic [NBANK-1:0]  bank_open,
    output logic [2:0]        pm_mode,
    output logic [LANES-1:0]  wr_lane_en,
    output logic [LANES-1:0]  rd_lane_oe,
    output logic [ADDR_W-1:0] mode_word
);

    cmd_e              cmd;
    pm_e               pm_e_mode;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  dqm_q;
    logic              run_en;
    logic              busy;
    logic              ap_close;
    logic [BANK_W-1:0] ap_bank;
    logic [NBANK-1:0]  open_nxt;
    logic              self_req;
    logic              autopre;

    // Self refresh request is REFRESH on the pins at the clock-enable drop.
    assign self_req = (decode_pins({cs_n, ras_n, cas_n, we_n}) == CMD_REF);
    assign autopre  = addr_q[AP_BIT] && (cmd == CMD_RD || cmd == CMD_WR);

    fe_capture #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_cap (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .dqm(dqm),
        .cmd(cmd), .bank_q(bank_q), .addr_q(addr_q), .dqm_q(dqm_q)
    );

    fe_bank_track #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank_q), .addr_q(addr_q),
        .ap_close(ap_close), .ap_bank(ap_bank),
        .bank_open(bank_open), .open_nxt(open_nxt), .cmd_err(cmd_err),
        .row_out(cmd_row), .mode_word(mode_word)
    );

    fe_burst_lane #(.BANK_W(BANK_W), .LANES(LANES), .BURST_LEN(BURST_LEN)) u_burst (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmd(cmd),
        .cmd_err(cmd_err), .bank(bank_q), .autopre(autopre), .dqm_q(dqm_q),
        .busy(busy), .ap_close(ap_close), .ap_bank(ap_bank),
        .wr_lane_en(wr_lane_en), .rd_lane_oe(rd_lane_oe)
    );

    fe_power u_pwr (
        .clk(clk), .rst_n(rst_n), .cke(cke), .self_req(self_req),
        .any_open(|open_nxt), .busy(busy),
        .pm_mode(pm_e_mode), .run_en(run_en)
    );

    assign cmd_valid   = (cmd != CMD_NONE);
    assign cmd_code    = cmd;
    assign cmd_bank    = bank_q;
    assign cmd_col     = addr_q[COL_W-1:0];
    assign cmd_autopre = autopre;
    assign pm_mode     = pm_e_mode;

endmodule

// File: tb/tb_sdram_cmd_front.sv
module tb_sdram_cmd_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [1:0]  dqm = '0;
    logic        cmd_valid, cmd_autopre, cmd_err;
    logic [2:0]  cmd_code, pm_mode;
    logic [1:0]  cmd_bank, wr_lane_en, rd_lane_oe;
    logic [11:0] cmd_row, mode_word;
    logic [7:0]  cmd_col;
    logic [3:0]  bank_open;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                           P_PRE = 4'b0010, P_REF = 4'b0001, P_LMR = 4'b0000,
                           P_NOP = 4'b0111;

    always #10 clk = ~clk;

    sdram_cmd_front dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
        .cmd_err(cmd_err), .bank_open(bank_open), .pm_mode(pm_mode),
        .wr_lane_en(wr_lane_en), .rd_lane_oe(rd_lane_oe), .mode_word(mode_word)
    );

    // Vector: pins {ctl4, ba2, addr12, dqm2}, expected {valid, code3, err, open4}
    localparam logic [28:0] VEC [16] = '{
        {P_ACT,   2'd0, 12'h123, 2'b00, 1'b1, 3'd1, 1'b0, 4'b0000},
        {P_NOP,   2'd0, 12'h000, 2'b00, 1'b0, 3'd0, 1'b0, 4'b0001},
        {P_ACT,   2'd0, 12'h777, 2'b00, 1'b1, 3'd1, 1'b1, 4'b0001},
        {P_RD,    2'd2, 12'h005, 2'b00, 1'b1, 3'd2, 1'b1, 4'b0001},
        {P_ACT,   2'd3, 12'hABC, 2'b00, 1'b1, 3'd1, 1'b0, 4'b0001},
        {4'b1011, 2'd1, 12'h456, 2'b00, 1'b0, 3'd0, 1'b0, 4'b1001},
        {P_WR,    2'd3, 12'h010, 2'b00, 1'b1, 3'd3, 1'b0, 4'b1001},
        {P_PRE,   2'd0, 12'h000, 2'b00, 1'b1, 3'd4, 1'b0, 4'b1001},
        {P_NOP,   2'd0, 12'h000, 2'b00, 1'b0, 3'd0, 1'b0, 4'b1000},
        {P_PRE,   2'd1, 12'h400, 2'b00, 1'b1, 3'd4, 1'b0, 4'b1000},
        {P_NOP,   2'd0, 12'h000, 2'b00, 1'b0, 3'd0, 1'b0, 4'b0000},
        {P_LMR,   2'd0, 12'h033, 2'b00, 1'b1, 3'd6, 1'b0, 4'b0000},
        {P_NOP,   2'd0, 12'h000, 2'b00, 1'b0, 3'd0, 1'b0, 4'b0000},
        {P_ACT,   2'd1, 12'h5A5, 2'b00, 1'b1, 3'd1, 1'b0, 4'b0000},
        {P_LMR,   2'd0, 12'h0FF, 2'b00, 1'b1, 3'd6, 1'b1, 4'b0010},
        {P_NOP,   2'd0, 12'h000, 2'b00, 1'b0, 3'd0, 1'b0, 4'b0010}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic setp(input logic [3:0] c, input logic [1:0] b,
                        input logic [11:0] a, input logic [1:0] d);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = b; addr = a; dqm = d;
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        setp(4'b1111, 2'd0, 12'h000, 2'b00);
        repeat (3) tick();
        // R1 reset state
        chk("R1 reset valid", cmd_valid, 1'b0);
        chk("R2 reset open", bank_open, 4'b0000);
        chk("R10 reset mode", pm_mode, 3'd0);
        chk("R7 reset word", mode_word, 12'h000);
        rst_n = 1'b1;

        for (int i = 0; i < 16; i++) begin
            logic [3:0] c; logic [1:0] b; logic [11:0] a; logic [1:0] d;
            logic ev; logic [2:0] ec; logic ee; logic [3:0] eo;
            {c, b, a, d, ev, ec, ee, eo} = VEC[i];
            setp(c, b, a, d);
            tick();
            chk("R1 valid", cmd_valid, ev);
            chk("R1 code", cmd_code, ec);
            chk("R6 err", cmd_err, ee);
            chk("R5 R2 open", bank_open, eo);
        end
        chk("R7 word kept", mode_word, 12'h033);

        // R3 read with auto-precharge on bank 1 (row 5A5)
        setp(P_RD, 2'd1, 12'h43C, 2'b00); tick();
        chk("R3 row", cmd_row, 12'h5A5);
        chk("R3 col", cmd_col, 8'h3C);
        chk("R3 autopre", cmd_autopre, 1'b1);
        chk("R3 bank", cmd_bank, 2'd1);
        setp(P_NOP, 2'd0, 12'h000, 2'b01); tick();
        chk("R9 oe k1", rd_lane_oe, 2'b11);
        setp(P_NOP, 2'd0, 12'h000, 2'b00); tick();
        chk("R9 oe k2", rd_lane_oe, 2'b11);
        tick();
        chk("R9 oe masked", rd_lane_oe, 2'b10);
        chk("R4 still open", bank_open, 4'b0010);
        tick();
        chk("R9 oe back", rd_lane_oe, 2'b11);
        chk("R4 open last", bank_open, 4'b0010);
        tick();
        chk("R9 oe end", rd_lane_oe, 2'b00);
        chk("R4 closed", bank_open, 4'b0000);

        // R8 write masking
        setp(P_WR, 2'd1, 12'h020, 2'b00); tick();
        chk("R6 wr closed err", cmd_err, 1'b1);
        chk("R8 wr closed lanes", wr_lane_en, 2'b00);
        setp(P_ACT, 2'd1, 12'h111, 2'b00); tick();
        setp(P_NOP, 2'd0, 12'h000, 2'b00); tick();
        setp(P_WR, 2'd1, 12'h020, 2'b10); tick();
        chk("R8 wr lane hi masked", wr_lane_en, 2'b01);
        setp(P_NOP, 2'd0, 12'h000, 2'b01); tick();
        chk("R8 burst lane lo masked", wr_lane_en, 2'b10);
        setp(P_PRE, 2'd0, 12'h400, 2'b00); tick();
        setp(P_NOP, 2'd0, 12'h000, 2'b00);
        repeat (4) tick();
        chk("R5 all closed", bank_open, 4'b0000);

        // R10 R11 precharge power-down
        cke = 1'b0; tick();
        chk("R10 pre pd", pm_mode, 3'd1);
        setp(P_ACT, 2'd0, 12'h001, 2'b00); tick();
        chk("R11 ignored cmd", cmd_valid, 1'b0);
        tick();
        chk("R11 no open", bank_open, 4'b0000);
        cke = 1'b1; #2;
        chk("R11 async exit", pm_mode, 3'd0);
        tick();
        chk("R11 exit edge ignored", cmd_valid, 1'b0);
        setp(P_NOP, 2'd0, 12'h000, 2'b00); tick();
        chk("R11 still closed", bank_open, 4'b0000);

        // R10 self refresh
        setp(P_REF, 2'd0, 12'h000, 2'b00); cke = 1'b0; tick();
        chk("R10 self refresh", pm_mode, 3'd2);
        chk("R11 ref ignored", cmd_valid, 1'b0);
        setp(P_NOP, 2'd0, 12'h000, 2'b00); cke = 1'b1; #2;
        chk("R11 sr async exit", pm_mode, 3'd0);
        tick(); tick();

        // R10 active power-down
        setp(P_ACT, 2'd2, 12'h0AB, 2'b00); tick();
        setp(P_NOP, 2'd0, 12'h000, 2'b00); tick();
        cke = 1'b0; tick();
        chk("R10 act pd", pm_mode, 3'd3);
        cke = 1'b1; tick(); tick();
        chk("R10 bank kept", bank_open, 4'b0100);

        // R12 clock suspend during a read burst
        setp(P_RD, 2'd2, 12'h001, 2'b00); tick();
        setp(P_NOP, 2'd0, 12'h000, 2'b00); tick();
        tick();
        cke = 1'b0; tick();
        chk("R10 suspend", pm_mode, 3'd4);
        chk("R12 oe frozen", rd_lane_oe, 2'b11);
        tick(); tick();
        chk("R12 still suspend", pm_mode, 3'd4);
        cke = 1'b1; #2;
        chk("R12 sync exit", pm_mode, 3'd4);
        tick();
        chk("R12 run", pm_mode, 3'd0);
        tick(); tick();
        chk("R12 burst resumes", rd_lane_oe, 2'b11);
        tick();
        chk("R12 burst done", rd_lane_oe, 2'b00);
        chk("R12 bank open", bank_open, 4'b0100);

        done = 1'b1;
        finish_run();
    end

endmodule